// File: doc/BRIEF.md
# Streaming Capture-to-Memory Write Controller

This block takes a stream of 64-bit sample words and writes a programmed number of them to a contiguous region of external memory. Each word packs four 16-bit samples. The memory side is a simplified burst write master. It has an address channel that carries a start address and a beat count, and a data channel that carries the beats and a last flag. Neither channel has a response path.

A one-cycle start command latches the word count, the base address and the debug selection, and clears the drop counter. The controller then waits until the memory side signals that it is ready. After that it counts arriving words until the programmed number has arrived. A FIFO holds the words while an address request is waiting to be accepted. A word that arrives while the FIFO is full is discarded, and a saturating counter records it.

In debug mode the controller stores a sample counter instead of the input data. Software can then check the stored contents against a known pattern. Gaps in that pattern show which words were discarded.

Top module: `capture_wr_ctrl`

## Requirements
- R1: A start pulse takes effect only while the controller is idle or done; a start pulse during a capture changes nothing. After an accepted start, no word is counted and no address request is made until `mem_ready` has been seen high.
- R2: In one capture exactly `cfg_size` input words are counted, including discarded ones. Input words that arrive after that are ignored.
- R3: The written words occupy consecutive addresses. The first is at `cfg_base`, and each following word is 8 bytes higher, across burst boundaries.
- R4: Each burst carries 16 beats, except the last one, which carries only the words that remain. `aw_len` equals the beat count minus one, and `w_last` is high exactly on the final beat of each burst.
- R5: The words that are kept are written in arrival order with their data unchanged. While `w_valid` is high and `w_ready` is low, `w_data` holds.
- R6: A counted word that arrives while the FIFO is full is discarded, even if a beat leaves the FIFO in the same cycle. `stat_drops` counts discarded words, stops at its all-ones value, and returns to zero on an accepted start.
- R7: With debug selected at start, the counted word number n (starting at 0) is stored with sample lane i (bits 16i+15 down to 16i) equal to 4n+i modulo 65536, and the input data is disregarded.
- R8: `stat_busy` is high from an accepted start until the capture ends. `stat_done` is high from the end of the capture until the next accepted start. The two are never high together, and both are low after reset.
- R9: A capture with `cfg_size` of zero ends without issuing any address request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle capture start command |
| cfg_size | input | SIZE_W | Number of words to capture |
| cfg_base | input | ADDR_W | Byte address of the first word |
| cfg_debug | input | 1 | Store counter pattern instead of input |
| mem_ready | input | 1 | Memory side ready to accept traffic |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 64 | Input word, four 16-bit lanes |
| aw_valid | output | 1 | Burst address request |
| aw_ready | input | 1 | Burst address accepted |
| aw_addr | output | ADDR_W | Burst start byte address |
| aw_len | output | log2(BURST) | Beats in burst minus one |
| w_valid | output | 1 | Write beat present |
| w_ready | input | 1 | Write beat accepted |
| w_data | output | 64 | Write beat data |
| w_last | output | 1 | Final beat of the burst |
| stat_busy | output | 1 | Capture in progress |
| stat_done | output | 1 | Capture finished |
| stat_drops | output | DROP_W | Saturating count of discarded words |

## Verification
Two functions can fall in the same cycle: a new word arrives and is counted, and a write beat leaves the FIFO. The bench provokes this by streaming words while it toggles `w_ready` in a fixed pattern. A scoreboard then judges order and content beat by beat, against both the plain data and the debug counter pattern. A second pairing is an arrival at a full FIFO together with a held address request. The bench provokes it by keeping `aw_ready` low so the FIFO fills. It then checks the exact set of words that survive, the saturated drop count, and that a start issued during the capture changes neither of them.

// File: rtl/capture_pkg.sv
// Shared types and constants for the capture write controller.
// Assumes a 64-bit word made of four 16-bit sample lanes.
package capture_pkg;
    localparam int SAMPLE_W = 16;
    localparam int LANES    = 4;
    localparam int WORD_W   = SAMPLE_W * LANES;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_WAIT = 2'd1,
        CAP_RUN  = 2'd2,
        CAP_DONE = 2'd3
    } cap_state_t;

    typedef enum logic [1:0] {
        BE_IDLE = 2'd0,
        BE_ADDR = 2'd1,
        BE_DATA = 2'd2
    } burst_state_t;
endpackage

// File: rtl/cap_fifo.sv
// Synchronous first-word-fall-through FIFO with an occupancy count.
// Assumes DEPTH is a power of two. The caller never pushes when full
// and never pops when empty. clear empties the FIFO.
module cap_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 512,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Store the pushed word at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push)
        else $error("push into full FIFO");

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop)
        else $error("pop from empty FIFO");
endmodule

// File: rtl/cap_intake.sv
// Counts the input words of a capture, selects plain or debug data,
// and pushes the word into the FIFO or discards it and counts the drop.
// Assumes SIZE_W >= 14 so that the debug lane values span 16 bits.
module cap_intake
    import capture_pkg::*;
#(
    parameter int SIZE_W = 32,
    parameter int DROP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SIZE_W-1:0] size,
    input  logic              debug,
    input  logic              run,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              fifo_full,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    output logic              all_in,
    output logic [DROP_W-1:0] drops
);
    logic [SIZE_W-1:0] size_q;
    logic [SIZE_W-1:0] arrived;
    logic              debug_q;
    logic              take;
    logic              drop;
    logic [WORD_W-1:0] dbg_word;

    // Latch the capture settings at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q  <= '0;
            debug_q <= 1'b0;
        end else if (start) begin
            size_q  <= size;
            debug_q <= debug;
        end
    end

    assign all_in = (arrived == size_q);
    assign take   = run && in_valid && !all_in;
    assign push   = take && !fifo_full;
    assign drop   = take && fifo_full;

    // Count the words of the capture, kept or discarded.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            arrived <= '0;
        end else if (take) begin
            arrived <= arrived + 1'b1;
        end
    end

    // Saturating count of discarded words.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            drops <= '0;
        end else if (drop && (drops != '1)) begin
            drops <= drops + 1'b1;
        end
    end

    // Build the debug pattern one sample lane at a time.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SIZE_W+1:0] lane_val;
        assign lane_val = {arrived, 2'b00} + (SIZE_W + 2)'(i);
        assign dbg_word[i*SAMPLE_W +: SAMPLE_W] = lane_val[SAMPLE_W-1:0];
    end

    assign push_data = debug_q ? dbg_word : in_data;

    p_drop_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> drops >= $past(drops))
        else $error("drop count went down without start");

    p_count_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        all_in && !start |=> all_in)
        else $error("word count passed the capture size");
endmodule

// File: rtl/cap_burst.sv
// Groups FIFO words into bursts. It issues one address request and
// then drains that burst's beats. Only one burst is in flight at a time.
// A burst is started with BURST words, or with the remainder once all
// input words have arrived. Assumes FIFO depth >= BURST.
module cap_burst
    import capture_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BURST  = 16,
    parameter int CNT_W  = 10,
    localparam int LEN_W  = $clog2(BURST),
    localparam int BEAT_W = $clog2(BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic              run,
    input  logic              all_in,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [WORD_W-1:0] head,
    output logic              pop,
    output logic              idle,
    output logic              aw_valid,
    input  logic              aw_ready,
    output logic [ADDR_W-1:0] aw_addr,
    output logic [LEN_W-1:0]  aw_len,
    output logic              w_valid,
    input  logic              w_ready,
    output logic [WORD_W-1:0] w_data,
    output logic              w_last
);
    burst_state_t      state;
    logic [ADDR_W-1:0] addr_q;
    logic [BEAT_W-1:0] len_q;
    logic [BEAT_W-1:0] beat_q;
    logic              want;
    logic [BEAT_W-1:0] pick;
    logic              final_beat;

    // Decide whether a burst can start and how long it is.
    always_comb begin
        want = 1'b0;
        pick = '0;
        if (fifo_count >= CNT_W'(BURST)) begin
            want = run;
            pick = BEAT_W'(BURST);
        end else if (all_in && (fifo_count != '0)) begin
            want = run;
            pick = BEAT_W'(fifo_count);
        end
    end

    assign final_beat = (beat_q == len_q - 1'b1);

    // Burst sequencer: pick a length, hold the address, drain the beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= BE_IDLE;
            addr_q <= '0;
            len_q  <= '0;
            beat_q <= '0;
        end else begin
            case (state)
                BE_IDLE: begin
                    if (start) begin
                        addr_q <= base;
                    end else if (want) begin
                        len_q  <= pick;
                        beat_q <= '0;
                        state  <= BE_ADDR;
                    end
                end
                BE_ADDR: begin
                    if (aw_ready) state <= BE_DATA;
                end
                BE_DATA: begin
                    if (w_ready) begin
                        beat_q <= beat_q + 1'b1;
                        if (final_beat) begin
                            addr_q <= addr_q + ADDR_W'({len_q, 3'b000});
                            state  <= BE_IDLE;
                        end
                    end
                end
                default: state <= BE_IDLE;
            endcase
        end
    end

    assign idle     = (state == BE_IDLE);
    assign aw_valid = (state == BE_ADDR);
    assign aw_addr  = addr_q;
    assign aw_len   = LEN_W'(len_q - 1'b1);
    assign w_valid  = (state == BE_DATA);
    assign w_data   = head;
    assign w_last   = w_valid && final_beat;
    assign pop      = w_valid && w_ready;

    p_aw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr) && $stable(aw_len))
        else $error("address request changed before acceptance");

    p_w_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_last))
        else $error("write beat changed before acceptance");

    p_last_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && w_ready && w_last |=> !w_valid)
        else $error("beat after last");
endmodule

// File: rtl/capture_wr_ctrl.sv
// Top of the capture write controller. The control FSM moves
// idle -> wait for memory -> run -> done. It connects the intake
// counter, the back-pressure FIFO and the burst sequencer.
// Assumes cmd_start is a single-cycle pulse and FIFO_DEPTH >= BURST.
module capture_wr_ctrl
    import capture_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 32,
    parameter int DROP_W     = 32,
    parameter int FIFO_DEPTH = 512,
    parameter int BURST      = 16,
    localparam int LEN_W     = $clog2(BURST),
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_debug,
    input  logic              mem_ready,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              aw_valid,
    input  logic              aw_ready,
    output logic [ADDR_W-1:0] aw_addr,
    output logic [LEN_W-1:0]  aw_len,
    output logic              w_valid,
    input  logic              w_ready,
    output logic [WORD_W-1:0] w_data,
    output logic              w_last,
    output logic              stat_busy,
    output logic              stat_done,
    output logic [DROP_W-1:0] stat_drops
);
    cap_state_t        state;
    logic              start_fire;
    logic              run;
    logic              all_in;
    logic              push;
    logic [WORD_W-1:0] push_data;
    logic              pop;
    logic [WORD_W-1:0] head;
    logic [CNT_W-1:0]  fifo_count;
    logic              fifo_full;
    logic              fifo_empty;
    logic              burst_idle;
    logic              finish;

    assign start_fire = cmd_start && ((state == CAP_IDLE) || (state == CAP_DONE));
    assign run        = (state == CAP_RUN);
    assign finish     = all_in && fifo_empty && burst_idle;

    // Capture control sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_IDLE;
        end else begin
            case (state)
                CAP_IDLE: if (start_fire) state <= CAP_WAIT;
                CAP_WAIT: if (mem_ready)  state <= CAP_RUN;
                CAP_RUN:  if (finish)     state <= CAP_DONE;
                CAP_DONE: if (start_fire) state <= CAP_WAIT;
                default:  state <= CAP_IDLE;
            endcase
        end
    end

    assign stat_busy = (state == CAP_WAIT) || (state == CAP_RUN);
    assign stat_done = (state == CAP_DONE);

    cap_intake #(
        .SIZE_W (SIZE_W),
        .DROP_W (DROP_W)
    ) u_intake (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_fire),
        .size      (cfg_size),
        .debug     (cfg_debug),
        .run       (run),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .fifo_full (fifo_full),
        .push      (push),
        .push_data (push_data),
        .all_in    (all_in),
        .drops     (stat_drops)
    );

    cap_fifo #(
        .W     (WORD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_fire),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (head),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    cap_burst #(
        .ADDR_W (ADDR_W),
        .BURST  (BURST),
        .CNT_W  (CNT_W)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_fire),
        .base       (cfg_base),
        .run        (run),
        .all_in     (all_in),
        .fifo_count (fifo_count),
        .head       (head),
        .pop        (pop),
        .idle       (burst_idle),
        .aw_valid   (aw_valid),
        .aw_ready   (aw_ready),
        .aw_addr    (aw_addr),
        .aw_len     (aw_len),
        .w_valid    (w_valid),
        .w_ready    (w_ready),
        .w_data     (w_data),
        .w_last     (w_last)
    );

    p_no_aw_early_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_WAIT) |-> !aw_valid && !w_valid)
        else $error("memory traffic before memory ready");

    p_status_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_busy && stat_done))
        else $error("busy and done together");

    p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done && !cmd_start |=> stat_done)
        else $error("done dropped without start");
endmodule

// File: tb/test_capture_wr_ctrl.sv
module test_capture_wr_ctrl;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 32;
    localparam int DROP_W = 3;
    localparam int DEPTH  = 32;
    localparam int BURST  = 16;
    localparam int LEN_W  = $clog2(BURST);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_start = 1'b0;
    logic [SIZE_W-1:0] cfg_size = '0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic              cfg_debug = 1'b0;
    logic              mem_ready = 1'b0;
    logic              in_valid = 1'b0;
    logic [63:0]       in_data = '0;
    logic              aw_valid;
    logic              aw_ready = 1'b1;
    logic [ADDR_W-1:0] aw_addr;
    logic [LEN_W-1:0]  aw_len;
    logic              w_valid;
    logic              w_ready = 1'b1;
    logic [63:0]       w_data;
    logic              w_last;
    logic              stat_busy;
    logic              stat_done;
    logic [DROP_W-1:0] stat_drops;

    int errors = 0;
    int checks = 0;
    logic [63:0] exp_q[$];
    logic [ADDR_W-1:0] exp_addr;
    int words_left = 0;
    int cur_len = 0;
    int beat = 0;
    int aw_seen = 0;
    logic stall_mode = 1'b0;
    int stall_tick = 0;

    always #2.5 clk = ~clk;

    capture_wr_ctrl #(
        .ADDR_W (ADDR_W), .SIZE_W (SIZE_W), .DROP_W (DROP_W),
        .FIFO_DEPTH (DEPTH), .BURST (BURST)
    ) i_capture_wr_ctrl (
        .clk (clk), .rst_n (rst_n), .cmd_start (cmd_start),
        .cfg_size (cfg_size), .cfg_base (cfg_base), .cfg_debug (cfg_debug),
        .mem_ready (mem_ready), .in_valid (in_valid), .in_data (in_data),
        .aw_valid (aw_valid), .aw_ready (aw_ready), .aw_addr (aw_addr),
        .aw_len (aw_len), .w_valid (w_valid), .w_ready (w_ready),
        .w_data (w_data), .w_last (w_last), .stat_busy (stat_busy),
        .stat_done (stat_done), .stat_drops (stat_drops)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: judges the handshakes that complete at the next edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (aw_valid && aw_ready) begin
                int want_len;
                want_len = (words_left < BURST) ? words_left : BURST;
                aw_seen++;
                check(aw_addr == exp_addr, "R3 burst address", aw_addr, exp_addr);
                check(int'(aw_len) + 1 == want_len, "R4 burst length",
                      aw_len + 1, want_len);
                cur_len = int'(aw_len) + 1;
                beat = 0;
            end
            if (w_valid && w_ready) begin
                logic [63:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 64'hDEAD;
                check(w_data == e, "R5 beat data", w_data, e);
                check(w_last == (beat == cur_len - 1), "R4 last flag", w_last,
                      (beat == cur_len - 1));
                beat++;
                exp_addr = exp_addr + 8;
                words_left--;
            end
        end
    end

    // Write-ready stall pattern generator.
    initial begin
        forever begin
            @(posedge clk); #1;
            stall_tick++;
            w_ready = stall_mode ? ((stall_tick % 3) != 1) : 1'b1;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic start_cap(input int size, input logic [ADDR_W-1:0] base,
                             input logic dbg);
        cfg_size = SIZE_W'(size); cfg_base = base; cfg_debug = dbg;
        cmd_start = 1'b1; tick(1); cmd_start = 1'b0;
        exp_addr = base;
    endtask

    // Driver: sends a word and pushes its expected image when it is kept.
    task automatic send(input logic [63:0] d, input bit kept, input bit dbg,
                        input int idx);
        logic [63:0] img;
        in_valid = 1'b1; in_data = d;
        for (int i = 0; i < 4; i++) img[16*i +: 16] = 16'(4 * idx + i);
        if (kept) exp_q.push_back(dbg ? img : d);
        tick(1);
        in_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!stat_done && n < 2000) begin tick(1); n++; end
        @(negedge clk);
        check(stat_done && !stat_busy, tag, {stat_busy, stat_done}, 2'b01);
        tick(0);
    endtask

    initial begin
        #(5 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3); rst_n = 1'b1;
        @(negedge clk);
        check(!stat_busy && !stat_done, "R8 reset status", {stat_busy, stat_done}, 0);
        check(stat_drops == 0, "R6 reset drops", stat_drops, 0);
        check(!aw_valid && !w_valid, "R1 reset idle channels", {aw_valid, w_valid}, 0);
        tick(1);

        // R1/R2/R3/R4: plain capture of 40 words, early and late input ignored.
        start_cap(40, 32'h0000_1000, 1'b0);
        words_left = 40;
        @(negedge clk);
        check(stat_busy, "R8 busy after start", stat_busy, 1);
        tick(0);
        for (int k = 0; k < 3; k++) send(64'hBAD0_0000 + k, 1'b0, 1'b0, 0);
        @(negedge clk);
        check(aw_seen == 0, "R1 no request before mem ready", aw_seen, 0);
        tick(0);
        mem_ready = 1'b1; tick(2);
        stall_mode = 1'b1;
        for (int k = 0; k < 40; k++) send({16'(k), 16'hA5A5, 32'(k * 7)}, 1'b1, 1'b0, k);
        for (int k = 0; k < 3; k++) send(64'hFFFF_0000 + k, 1'b0, 1'b0, 0);
        wait_done("R8 done after plain capture");
        check(exp_q.size() == 0, "R2 all words written", exp_q.size(), 0);
        check(aw_seen == 3, "R4 three bursts for 40 words", aw_seen, 3);
        check(words_left == 0, "R2 beat total", words_left, 0);
        stall_mode = 1'b0;

        // R6: FIFO overflow with the address channel held off.
        aw_ready = 1'b0; aw_seen = 0;
        start_cap(40, 32'h0002_0000, 1'b0);
        @(negedge clk);
        check(stat_drops == 0, "R6 drops cleared at start", stat_drops, 0);
        tick(0);
        tick(2);
        words_left = 32;
        for (int k = 0; k < 40; k++) send(64'h5000 + k, k < DEPTH, 1'b0, k);
        @(negedge clk);
        check(stat_drops == 3'd7, "R6 drop count saturates", stat_drops, 7);
        tick(0);
        cfg_size = 5; cfg_base = 32'h0; cmd_start = 1'b1; tick(1); cmd_start = 1'b0;
        @(negedge clk);
        check(stat_drops == 3'd7 && stat_busy, "R1 start while busy ignored",
              {stat_busy, stat_drops}, {1'b1, 3'd7});
        tick(0);
        aw_ready = 1'b1;
        wait_done("R8 done after overflow capture");
        check(exp_q.size() == 0 && words_left == 0, "R6 kept words written",
              exp_q.size(), 0);
        check(aw_seen == 2, "R4 two bursts after overflow", aw_seen, 2);

        // R7: debug pattern with stalls, partial final burst.
        aw_seen = 0; stall_mode = 1'b1;
        start_cap(20, 32'h0000_8000, 1'b1);
        words_left = 20;
        tick(2);
        for (int k = 0; k < 20; k++) send(64'h1234_5678_9ABC_DEF0, 1'b1, 1'b1, k);
        wait_done("R8 done after debug capture");
        check(exp_q.size() == 0, "R7 debug words written", exp_q.size(), 0);
        check(aw_seen == 2, "R4 bursts of 16 and 4", aw_seen, 2);
        stall_mode = 1'b0;

        // R9: zero-size capture.
        aw_seen = 0; words_left = 0;
        start_cap(0, 32'h0000_4000, 1'b0);
        wait_done("R9 zero size ends");
        check(aw_seen == 0, "R9 no burst for zero size", aw_seen, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule